// File: doc/BRIEF.md
# Event-Triggered Sync Counter Request Queue

This block lets software arm sync counters against capture events. Software writes a request that names a capture condition and a counter. The request waits in a short queue owned by that condition. When the condition's hardware pulse arrives, the oldest waiting request leaves the queue and its counter is incremented by one. Software waits on the counters elsewhere; that logic is outside this block.

Conditions exist per capture port: a frame-start pulse and a memory-write-acknowledge pulse. Each condition owns a two-entry queue. A control bit chooses what a request aimed at a full queue does. With the bit clear, the write port stalls until the queue drains. With the bit set, the request is thrown away and a sticky error bit for that condition is raised. Software clears error bits by writing ones.

Counters are read through a select/value pair. A separate strobe lets software add one to any counter directly.

Top module: `sync_event_queue`

## Requirements
- R1: A write to offset 0x000 is a request. Its condition code is taken from bits [15:8], and the counter index from bits [2:0]. Bits [7:3] are ignored.
- R2: When the event of a condition is high at a clock edge and that condition's queue is not empty, the head request is removed at that edge. The counter it names reads one higher from the next cycle on.
- R3: Each condition has its own queue of two entries. Requests retire oldest first. Frame start on port p uses code 5+4p, and memory-write acknowledge on port p uses code 7+4p (p = 0..3).
- R4: When bit 8 of the control register (offset 0x004) is 0, a request to a full queue holds wr_ready low. The request is taken in the first cycle that begins with a free entry. Fullness is judged at the start of the cycle, so a retirement in the same cycle does not free the entry early.
- R5: When control bit 8 is 1, a request to a full queue is accepted with wr_ready high and then discarded. Error register (offset 0x008) bit c is set, where c is the condition code.
- R6: Writing a value to offset 0x008 clears each error bit that is 1 in that value. Other error bits keep their state.
- R7: An event whose queue is empty changes no counter.
- R8: A software strobe adds one to the counter it selects. If the strobe and a retirement hit the same counter in the same cycle, that counter advances by two.
- R9: Reset clears all counters, queues, error bits and the control bit. Reading offset 0x004 returns the control bit at bit 8 and 0 in every other bit.
- R10: A request whose condition code matches no condition is accepted and has no effect on any queue, counter or error bit.
- R11: Retirements from several conditions that name the same counter in one cycle all count, together with the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write request |
| wr_addr | input | 12 | Write byte offset |
| wr_data | input | 32 | Write data |
| wr_ready | output | 1 | Write accepted this cycle when high |
| rd_addr | input | 12 | Read byte offset |
| rd_data | output | 32 | Read data (combinational) |
| frame_start_evt | input | 4 | Frame-start pulse per port |
| mem_ack_evt | input | 4 | Memory-write-acknowledge pulse per port |
| sw_inc | input | 1 | Software increment strobe |
| sw_inc_idx | input | 3 | Counter for the strobe |
| cnt_sel | input | 3 | Counter to read |
| cnt_value | output | 32 | Value of the selected counter |

## Verification
Several properties are checked on every cycle:
- A stalled write only ever occurs with the control bit clear.
- Every dropped request leaves its error bit set on the next cycle.
- An error write clears the bits it names.
- Error bits stay still when nothing sets or clears them.
- A counter neither moves without an increment source nor jumps further than the number of sources.

Only the bench's scenarios can show the rest: retirement order, that the right counter receives each retirement, that the stall releases at the right cycle, and that codes outside the condition list are harmless. The bench compares these against a queue model in the test.

// File: rtl/sync_evq_pkg.sv
`timescale 1ns/100ps
package sync_evq_pkg;

  localparam int unsigned REQ_OFFSET  = 0;
  localparam int unsigned CTRL_OFFSET = 4;
  localparam int unsigned ERR_OFFSET  = 8;
  localparam int unsigned NOSTALL_BIT = 8;
  localparam int unsigned CODE_LSB    = 8;
  localparam int unsigned CODE_W      = 8;
  localparam int unsigned FS_BASE     = 5;
  localparam int unsigned MW_BASE     = 7;
  localparam int unsigned PORT_STRIDE = 4;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_REQ,
    SEL_CTRL,
    SEL_ERR
  } reg_sel_e;

  // Condition slot j: even slots are frame start, odd slots are write ack, port j/2.
  function automatic int unsigned cond_code(input int unsigned j);
    return ((j % 2) == 0) ? FS_BASE + PORT_STRIDE * (j / 2)
                          : MW_BASE + PORT_STRIDE * (j / 2);
  endfunction

  function automatic reg_sel_e decode_addr(input logic [31:0] a);
    reg_sel_e s;
    case (a)
      32'(REQ_OFFSET):  s = SEL_REQ;
      32'(CTRL_OFFSET): s = SEL_CTRL;
      32'(ERR_OFFSET):  s = SEL_ERR;
      default:          s = SEL_NONE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/sync_evq_fifo.sv
`timescale 1ns/100ps
module sync_evq_fifo #(
  parameter int unsigned DEPTH = 2,
  parameter int unsigned WIDTH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] head_o,
  output logic             empty_o,
  output logic             full_o
);

  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned OCC_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] rd_q, rd_d, wr_q, wr_d;
  logic [OCC_W-1:0] occ_q, occ_d;

  always_comb begin
    rd_d  = rd_q;
    wr_d  = wr_q;
    occ_d = occ_q;
    if (push_i) wr_d = (wr_q == LAST) ? '0 : wr_q + 1'b1;
    if (pop_i)  rd_d = (rd_q == LAST) ? '0 : rd_q + 1'b1;
    case ({push_i, pop_i})
      2'b10:   occ_d = occ_q + 1'b1;
      2'b01:   occ_d = occ_q - 1'b1;
      default: occ_d = occ_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      occ_q <= '0;
    end else begin
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      occ_q <= occ_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < DEPTH; s++) mem_q[s] <= '0;
    end else begin
      for (int s = 0; s < DEPTH; s++) begin
        if (push_i && (wr_q == PTR_W'(s))) mem_q[s] <= data_i;
      end
    end
  end

  assign head_o  = mem_q[rd_q];
  assign empty_o = (occ_q == '0);
  assign full_o  = (occ_q == OCC_W'(DEPTH));

endmodule

// File: rtl/sync_evq_counters.sv
`timescale 1ns/100ps
module sync_evq_counters #(
  parameter int unsigned NUM_CNT = 8,
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned NUM_SRC = 8,
  localparam int unsigned IDX_W  = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_SRC-1:0]              src_vld_i,
  input  logic [NUM_SRC-1:0][IDX_W-1:0]   src_idx_i,
  input  logic                            sw_inc_i,
  input  logic [IDX_W-1:0]                sw_idx_i,
  input  logic [IDX_W-1:0]                rd_sel_i,
  output logic [CNT_W-1:0]                rd_val_o
);

  localparam int unsigned AMT_W = $clog2(NUM_SRC + 2);

  logic [CNT_W-1:0] cnt_q [NUM_CNT];
  logic [CNT_W-1:0] cnt_d [NUM_CNT];
  logic [AMT_W-1:0] amt   [NUM_CNT];
  logic [NUM_CNT-1:0] cnt_en;

  // Every source that names counter k contributes one step to it.
  always_comb begin
    for (int k = 0; k < NUM_CNT; k++) begin
      amt[k] = '0;
      for (int s = 0; s < NUM_SRC; s++) begin
        if (src_vld_i[s] && (src_idx_i[s] == IDX_W'(k))) amt[k] = amt[k] + AMT_W'(1);
      end
      if (sw_inc_i && (sw_idx_i == IDX_W'(k))) amt[k] = amt[k] + AMT_W'(1);
      cnt_en[k] = (amt[k] != '0);
      cnt_d[k]  = cnt_q[k] + CNT_W'(amt[k]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NUM_CNT; k++) cnt_q[k] <= '0;
    end else begin
      for (int k = 0; k < NUM_CNT; k++) begin
        if (cnt_en[k]) cnt_q[k] <= cnt_d[k];
      end
    end
  end

  assign rd_val_o = cnt_q[rd_sel_i];

endmodule

// File: rtl/sync_evq_regs.sv
`timescale 1ns/100ps
module sync_evq_regs
  import sync_evq_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_fire_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [DATA_W-1:0] drop_bits_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic              no_stall_o,
  output logic [DATA_W-1:0] err_o,
  output logic [DATA_W-1:0] rd_data_o
);

  reg_sel_e          wr_sel, rd_sel;
  logic              ns_q, ns_d, ns_en;
  logic [DATA_W-1:0] err_q, err_d;
  logic              err_en;

  assign wr_sel = decode_addr(32'(wr_addr_i));
  assign rd_sel = decode_addr(32'(rd_addr_i));

  always_comb begin
    ns_en  = wr_fire_i && (wr_sel == SEL_CTRL);
    ns_d   = wr_data_i[NOSTALL_BIT];
    err_en = (wr_fire_i && (wr_sel == SEL_ERR)) || (drop_bits_i != '0);
    err_d  = err_q;
    if (wr_fire_i && (wr_sel == SEL_ERR)) err_d = err_d & ~wr_data_i;
    err_d  = err_d | drop_bits_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ns_q  <= 1'b0;
      err_q <= '0;
    end else begin
      if (ns_en)  ns_q  <= ns_d;
      if (err_en) err_q <= err_d;
    end
  end

  always_comb begin
    rd_data_o = '0;
    case (rd_sel)
      SEL_CTRL: rd_data_o[NOSTALL_BIT] = ns_q;
      SEL_ERR:  rd_data_o = err_q;
      default:  rd_data_o = '0;
    endcase
  end

  assign no_stall_o = ns_q;
  assign err_o      = err_q;

endmodule

// File: rtl/sync_event_queue.sv
`timescale 1ns/100ps
module sync_event_queue
  import sync_evq_pkg::*;
#(
  parameter int unsigned NUM_PORTS  = 4,
  parameter int unsigned NUM_CNT    = 8,
  parameter int unsigned CNT_W      = 32,
  parameter int unsigned FIFO_DEPTH = 2,
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned DATA_W     = 32,
  localparam int unsigned IDX_W     = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [DATA_W-1:0]    wr_data,
  output logic                 wr_ready,
  input  logic [ADDR_W-1:0]    rd_addr,
  output logic [DATA_W-1:0]    rd_data,
  input  logic [NUM_PORTS-1:0] frame_start_evt,
  input  logic [NUM_PORTS-1:0] mem_ack_evt,
  input  logic                 sw_inc,
  input  logic [IDX_W-1:0]     sw_inc_idx,
  input  logic [IDX_W-1:0]     cnt_sel,
  output logic [CNT_W-1:0]     cnt_value
);

  localparam int unsigned NCOND = 2 * NUM_PORTS;

  logic                        req_hit, wr_fire, blocked, no_stall;
  logic [CODE_W-1:0]           req_code;
  logic [IDX_W-1:0]            req_idx;
  logic [NCOND-1:0]            cond_hit, evt, push, pop, drop;
  logic [NCOND-1:0]            fifo_empty, fifo_full;
  logic [NCOND-1:0][IDX_W-1:0] head;
  logic [DATA_W-1:0]           drop_bits, err_bits;

  assign req_hit  = wr_en && (decode_addr(32'(wr_addr)) == SEL_REQ);
  assign req_code = wr_data[CODE_LSB +: CODE_W];
  assign req_idx  = wr_data[IDX_W-1:0];
  assign blocked  = req_hit && ((cond_hit & fifo_full) != '0) && !no_stall;
  assign wr_ready = !blocked;
  assign wr_fire  = wr_en && wr_ready;

  for (genvar j = 0; j < NCOND; j++) begin : g_cond
    localparam int unsigned CODE = cond_code(j);

    assign cond_hit[j] = (req_code == CODE_W'(CODE));

    if ((j % 2) == 0) begin : g_fs
      assign evt[j] = frame_start_evt[j/2];
    end else begin : g_mw
      assign evt[j] = mem_ack_evt[j/2];
    end

    assign push[j] = wr_fire && req_hit && cond_hit[j] && !fifo_full[j];
    assign drop[j] = wr_fire && req_hit && cond_hit[j] &&  fifo_full[j];
    assign pop[j]  = evt[j] && !fifo_empty[j];

    sync_evq_fifo #(
      .DEPTH (FIFO_DEPTH),
      .WIDTH (IDX_W)
    ) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .push_i  (push[j]),
      .pop_i   (pop[j]),
      .data_i  (req_idx),
      .head_o  (head[j]),
      .empty_o (fifo_empty[j]),
      .full_o  (fifo_full[j])
    );
  end

  // Error bit position equals the condition code.
  always_comb begin
    drop_bits = '0;
    for (int j = 0; j < NCOND; j++) drop_bits[cond_code(j)] = drop[j];
  end

  sync_evq_regs #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_fire_i   (wr_fire),
    .wr_addr_i   (wr_addr),
    .wr_data_i   (wr_data),
    .drop_bits_i (drop_bits),
    .rd_addr_i   (rd_addr),
    .no_stall_o  (no_stall),
    .err_o       (err_bits),
    .rd_data_o   (rd_data)
  );

  sync_evq_counters #(
    .NUM_CNT (NUM_CNT),
    .CNT_W   (CNT_W),
    .NUM_SRC (NCOND)
  ) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_vld_i (pop),
    .src_idx_i (head),
    .sw_inc_i  (sw_inc),
    .sw_idx_i  (sw_inc_idx),
    .rd_sel_i  (cnt_sel),
    .rd_val_o  (cnt_value)
  );

endmodule

// File: rtl/sync_event_queue_checker.sv
`timescale 1ns/100ps
module sync_event_queue_checker
  import sync_evq_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 4,
  parameter int unsigned NUM_CNT   = 8,
  parameter int unsigned CNT_W     = 32,
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned DATA_W    = 32,
  localparam int unsigned IDX_W    = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1,
  localparam int unsigned NCOND    = 2 * NUM_PORTS
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              no_stall,
  input logic [DATA_W-1:0] err_bits,
  input logic [DATA_W-1:0] drop_bits,
  input logic [NCOND-1:0]  pop,
  input logic              sw_inc,
  input logic [IDX_W-1:0]  cnt_sel,
  input logic [CNT_W-1:0]  cnt_value
);

  logic err_wr;
  assign err_wr = wr_en && wr_ready && (wr_addr == ADDR_W'(ERR_OFFSET));

  // R4: a held write happens only in stall mode
  a_r4_stall_only_in_stall_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_ready) |-> !no_stall);

  // R5: each dropped request leaves its condition's error bit set
  a_r5_drop_sets_error: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_bits != '0) |=> ((err_bits & $past(drop_bits)) == $past(drop_bits)));

  // R6: written ones clear the error bits
  a_r6_write_ones_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (err_wr && (drop_bits == '0)) |=> ((err_bits & $past(wr_data)) == '0));

  // R6: with no write and no drop, the error bits hold
  a_r6_error_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!err_wr && (drop_bits == '0)) |=> $stable(err_bits));

  // R7: a counter moves only when a retirement or strobe occurs
  a_r7_no_source_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_inc && (pop == '0)) |=> ((cnt_sel != $past(cnt_sel)) || (cnt_value == $past(cnt_value))));

  // R11: a counter never steps further than the number of sources
  a_r11_step_bound: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((cnt_sel != $past(cnt_sel)) ||
              ((cnt_value - $past(cnt_value)) <= CNT_W'(NCOND + 1))));

endmodule

bind sync_event_queue sync_event_queue_checker #(
  .NUM_PORTS (NUM_PORTS),
  .NUM_CNT   (NUM_CNT),
  .CNT_W     (CNT_W),
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W)
) u_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_ready  (wr_ready),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .no_stall  (no_stall),
  .err_bits  (err_bits),
  .drop_bits (drop_bits),
  .pop       (pop),
  .sw_inc    (sw_inc),
  .cnt_sel   (cnt_sel),
  .cnt_value (cnt_value)
);

// File: tb/sync_event_queue_test.sv
`timescale 1ns/100ps
module sync_event_queue_test;

  localparam int NP = 4;
  localparam int NC = 8;
  localparam int NQ = 2 * NP;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [11:0] wr_addr;
  logic [31:0] wr_data;
  logic        wr_ready;
  logic [11:0] rd_addr;
  logic [31:0] rd_data;
  logic [3:0]  frame_start_evt;
  logic [3:0]  mem_ack_evt;
  logic        sw_inc;
  logic [2:0]  sw_inc_idx;
  logic [2:0]  cnt_sel;
  logic [31:0] cnt_value;

  always #10 clk = ~clk;

  sync_event_queue uut (
    .clk             (clk),
    .rst_n           (rst_n),
    .wr_en           (wr_en),
    .wr_addr         (wr_addr),
    .wr_data         (wr_data),
    .wr_ready        (wr_ready),
    .rd_addr         (rd_addr),
    .rd_data         (rd_data),
    .frame_start_evt (frame_start_evt),
    .mem_ack_evt     (mem_ack_evt),
    .sw_inc          (sw_inc),
    .sw_inc_idx      (sw_inc_idx),
    .cnt_sel         (cnt_sel),
    .cnt_value       (cnt_value)
  );

  int          n_chk = 0;
  int          n_err = 0;
  bit          done  = 0;
  logic        last_ready;
  logic [31:0] m_cnt [NC];
  int          m_q   [NQ][2];
  int          m_n   [NQ];
  logic [31:0] m_err;
  bit          m_ns;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic int code_of(input int j);
    return (((j % 2) == 0) ? 5 : 7) + 4 * (j / 2);
  endfunction

  function automatic int cidx(input logic [7:0] c);
    for (int j = 0; j < NQ; j++) if (int'(c) == code_of(j)) return j;
    return -1;
  endfunction

  task automatic model_clear();
    for (int k = 0; k < NC; k++) m_cnt[k] = 0;
    for (int j = 0; j < NQ; j++) m_n[j] = 0;
    m_err = 0;
    m_ns  = 0;
  endtask

  task automatic rdc(input int k, output logic [31:0] v);
    cnt_sel = k[2:0];
    #0.2;
    v = cnt_value;
  endtask

  task automatic rdr(input logic [11:0] a, output logic [31:0] v);
    rd_addr = a;
    #0.2;
    v = rd_data;
  endtask

  task automatic check_all();
    logic [31:0] v;
    for (int k = 0; k < NC; k++) begin
      rdc(k, v);
      chk("R2 counter value", v, m_cnt[k]);
    end
    rdr(12'h008, v);
    chk("R5/R6 error register", v, m_err);
    rdr(12'h004, v);
    chk("R9 control register", v, m_ns ? 32'h100 : 32'h0);
  endtask

  task automatic cycle(input logic we, input logic [11:0] a, input logic [31:0] d,
                       input logic [3:0] fs, input logic [3:0] mw,
                       input logic si, input logic [2:0] sx);
    bit exp_rdy;
    int c;
    int pre_n [NQ];
    int inc   [NC];
    wr_en = we; wr_addr = a; wr_data = d;
    frame_start_evt = fs; mem_ack_evt = mw; sw_inc = si; sw_inc_idx = sx;
    c = (a == 12'h000) ? cidx(d[15:8]) : -1;
    exp_rdy = !(we && (a == 12'h000) && (c >= 0) && (m_n[c] == 2) && !m_ns);
    #1;
    last_ready = wr_ready;
    chk("R4/R5 write ready", {31'b0, wr_ready}, {31'b0, exp_rdy});
    @(posedge clk);
    for (int k = 0; k < NC; k++) inc[k] = 0;
    for (int j = 0; j < NQ; j++) begin
      bit ev;
      pre_n[j] = m_n[j];
      ev = ((j % 2) == 0) ? fs[j/2] : mw[j/2];
      if (ev && (m_n[j] > 0)) begin
        inc[m_q[j][0]]++;
        m_q[j][0] = m_q[j][1];
        m_n[j]--;
      end
    end
    if (si) inc[sx]++;
    if (we && exp_rdy) begin
      if (a == 12'h000 && c >= 0) begin
        if (pre_n[c] == 2) m_err[code_of(c)] = 1'b1;
        else begin
          m_q[c][m_n[c]] = int'(d[2:0]);
          m_n[c]++;
        end
      end else if (a == 12'h004) begin
        m_ns = d[8];
      end else if (a == 12'h008) begin
        m_err = m_err & ~d;
      end
    end
    for (int k = 0; k < NC; k++) m_cnt[k] = m_cnt[k] + 32'(inc[k]);
    @(negedge clk);
    wr_en = 0; frame_start_evt = 0; mem_ack_evt = 0; sw_inc = 0;
    check_all();
  endtask

  task automatic wreq(input int code, input logic [7:0] low);
    cycle(1'b1, 12'h000, {16'h0, 8'(code), low}, 4'h0, 4'h0, 1'b0, 3'd0);
  endtask

  task automatic ev(input logic [3:0] fs, input logic [3:0] mw, input logic si, input logic [2:0] sx);
    cycle(1'b0, 12'h000, 32'h0, fs, mw, si, sx);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    wr_en = 0; wr_addr = 0; wr_data = 0; rd_addr = 0;
    frame_start_evt = 0; mem_ack_evt = 0; sw_inc = 0; sw_inc_idx = 0; cnt_sel = 0;
    model_clear();
    repeat (2) @(negedge clk);
    check_all();
    rst_n = 1'b1;
    @(negedge clk);
    check_all();
  endtask

  initial begin
    #(20.0 * 150000);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired before the run ended");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, base;
    void'($urandom(32'd20240611));
    do_reset();

    // R9: reset state
    rdc(3, v); chk("R9 counter zero after reset", v, 32'h0);
    rdr(12'h008, v); chk("R9 error zero after reset", v, 32'h0);

    // R1 and R2: request, then matching frame start on port 0
    wreq(5, 8'h03);
    ev(4'b0001, 4'b0000, 1'b0, 3'd0);
    rdc(3, v); chk("R2 retire increments named counter", v, 32'd1);

    // R3: oldest first on write ack port 0 (code 7)
    wreq(7, 8'h01);
    wreq(7, 8'h02);
    ev(4'b0000, 4'b0001, 1'b0, 3'd0);
    rdc(1, v); chk("R3 first request retires first", v, 32'd1);
    rdc(2, v); chk("R3 second request still queued", v, 32'd0);
    ev(4'b0000, 4'b0001, 1'b0, 3'd0);
    rdc(2, v); chk("R3 second request retires next", v, 32'd1);

    // R7: event with empty queue
    ev(4'b0010, 4'b1111, 1'b0, 3'd0);
    rdc(3, v); chk("R7 empty-queue event ignored", v, 32'd1);
    rdc(2, v); chk("R7 empty-queue event ignored", v, 32'd1);

    // R4: stall on a full queue (code 9 = frame start port 1)
    wreq(9, 8'h04);
    wreq(9, 8'h05);
    wreq(9, 8'h06);
    chk("R4 full queue holds ready low", {31'b0, last_ready}, 32'd0);
    cycle(1'b1, 12'h000, 32'h0906, 4'b0010, 4'b0000, 1'b0, 3'd0);
    chk("R4 retire in same cycle does not release", {31'b0, last_ready}, 32'd0);
    wreq(9, 8'h06);
    chk("R4 write accepted once entry free", {31'b0, last_ready}, 32'd1);
    ev(4'b0010, 4'b0000, 1'b0, 3'd0);
    ev(4'b0010, 4'b0000, 1'b0, 3'd0);
    rdc(6, v); chk("R4 stalled request was queued", v, 32'd1);
    rdr(12'h008, v); chk("R4 stall raises no error", v, 32'h0);

    // R5: drop mode on code 11 (write ack port 1)
    cycle(1'b1, 12'h004, 32'h0000_0100, 4'h0, 4'h0, 1'b0, 3'd0);
    rdr(12'h004, v); chk("R9 control readback bit 8", v, 32'h100);
    wreq(11, 8'h07);
    wreq(11, 8'h07);
    wreq(11, 8'h07);
    chk("R5 drop keeps ready high", {31'b0, last_ready}, 32'd1);
    rdr(12'h008, v); chk("R5 drop sets bit 11", v, 32'h800);
    ev(4'b0000, 4'b0010, 1'b0, 3'd0);
    ev(4'b0000, 4'b0010, 1'b0, 3'd0);
    ev(4'b0000, 4'b0010, 1'b0, 3'd0);
    rdc(7, v); chk("R5 dropped request never retires", v, 32'd2);

    // R6: write-ones-to-clear
    cycle(1'b1, 12'h008, 32'h0, 4'h0, 4'h0, 1'b0, 3'd0);
    rdr(12'h008, v); chk("R6 zero write keeps bits", v, 32'h800);
    cycle(1'b1, 12'h008, 32'h800, 4'h0, 4'h0, 1'b0, 3'd0);
    rdr(12'h008, v); chk("R6 ones clear bits", v, 32'h0);

    // R8: strobe alone, then strobe coinciding with retirement (code 17 = fs port 3)
    rdc(0, base);
    ev(4'h0, 4'h0, 1'b1, 3'd0);
    rdc(0, v); chk("R8 strobe adds one", v, base + 1);
    wreq(17, 8'h00);
    ev(4'b1000, 4'h0, 1'b1, 3'd0);
    rdc(0, v); chk("R8 coincident increments add two", v, base + 3);

    // R10: unmatched codes
    wreq(6, 8'h01);
    wreq(8'h17, 8'h01);
    chk("R10 unmatched code accepted", {31'b0, last_ready}, 32'd1);
    rdc(1, base);
    ev(4'hF, 4'hF, 1'b0, 3'd0);
    rdc(1, v); chk("R10 unmatched code queues nothing", v, base);
    rdr(12'h008, v); chk("R10 unmatched code raises no error", v, 32'h0);

    // R11: three conditions retire into one counter together
    rdc(2, base);
    wreq(15, 8'h02);
    wreq(17, 8'h02);
    wreq(19, 8'h02);
    ev(4'b1000, 4'b1100, 1'b0, 3'd0);
    rdc(2, v); chk("R11 simultaneous retirements sum", v, base + 3);

    // R1: bits [7:3] of the request are ignored
    rdc(1, base);
    wreq(5, 8'hF9);
    ev(4'b0001, 4'h0, 1'b0, 3'd0);
    rdc(1, v); chk("R1 index from low three bits", v, base + 1);

    // Mixed random traffic against the model, both stall modes
    for (int i = 0; i < 1500; i++) begin
      int r;
      logic [11:0] a;
      logic [31:0] d;
      logic [7:0]  code;
      r = $urandom_range(0, 9);
      code = (r < 8) ? 8'(code_of(r)) : ((r == 8) ? 8'd6 : 8'h13 + 8'd4);
      case ($urandom_range(0, 9))
        0:       begin a = 12'h004; d = $urandom; end
        1:       begin a = 12'h008; d = $urandom; end
        2:       begin a = 12'h010; d = $urandom; end
        default: begin a = 12'h000; d = {16'h0, code, 8'($urandom)}; end
      endcase
      cycle(1'($urandom_range(0, 1)), a, d,
            4'($urandom) & 4'($urandom), 4'($urandom) & 4'($urandom),
            1'($urandom_range(0, 3) == 0), 3'($urandom));
    end

    // R9: a second reset clears everything built up
    do_reset();
    rdc(2, v); chk("R9 counters clear on reset", v, 32'h0);
    ev(4'hF, 4'hF, 1'b0, 3'd0);
    rdc(2, v); chk("R9 queues clear on reset", v, 32'h0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule